// File: doc/BRIEF.md
# End-of-Discharge Voltage Flag Monitor

This block follows a stream of digitized single-cell voltage samples, expressed in millivolts, and keeps two sticky warning flags. The *low* flag marks an early warning. The *empty* flag marks a depleted cell. Each flag sets when an accepted sample lies strictly below its own programmable threshold. It then holds, whatever later samples show, until a valid-charge event or a soft reset clears it.

While an external high-discharge-rate indicator is asserted, comparison is blanked. After the indicator drops, comparison stays blanked for a further holdoff of half a second, which is counted in clock cycles. If the indicator rises again during the holdoff, the count starts over.

A small register port handles the rest. It writes the two thresholds, issues a soft-reset command, and reads back the thresholds and the most recent sample.

Top module: `eod_monitor`

## Requirements
- R1: After rst_ni is released, both flags are 0, last_mv_o is 0, and register reads return 1520 at address 0x30 and 1470 at address 0x32.
- R2: An accepted sample (smp_vld_i=1 while comparison is enabled) strictly below the low threshold sets low_flag_o at the next clock edge. A sample equal to or above the threshold leaves the flag unchanged.
- R3: An accepted sample strictly below the empty threshold sets empty_flag_o at the next clock edge, independently of low_flag_o. A sample equal to the threshold does not set it.
- R4: A set flag stays set after later samples at any value, including values above both thresholds.
- R5: chg_evt_i=1 clears both flags at the next edge. This takes priority over a below-threshold sample in the same cycle.
- R6: While hi_rate_i=1, samples never set a flag.
- R7: After hi_rate_i falls, comparison resumes on the (HOLD_CYC+1)-th cycle with hi_rate_i low, where HOLD_CYC = CLK_HZ/2. A sample in any earlier cycle is ignored. Any cycle with hi_rate_i=1 restarts the count.
- R8: A write (reg_we_i=1) to address 0x30 sets the low threshold and a write to 0x32 sets the empty threshold, each from reg_wdata_i[11:0]. A sample in the same cycle as the write uses the old value. Later samples use the new one, and reads return it.
- R9: Writing data 0x0080 to address 0x39 clears both flags and restores the default thresholds. Any other data value at 0x39 has no effect.
- R10: Every sample with smp_vld_i=1, whether blanked or not, is copied into last_mv_o at the next edge and reads back at address 0x34. Unmapped read addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_mv_i | input | 12 | Cell voltage sample in mV |
| hi_rate_i | input | 1 | Discharge rate above 2C |
| chg_evt_i | input | 1 | Valid-charge event |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register address (read and write) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| low_flag_o | output | 1 | Early-warning flag |
| empty_flag_o | output | 1 | Empty flag |
| last_mv_o | output | 12 | Last sampled voltage |

## Verification
Samples are stepped across each threshold at one above, exactly equal, and one below. This separates strict from inclusive comparison, and also separates the two flags from each other.

Samples are presented while blanked and at the last ignored and first accepted holdoff cycles, including a restart partway through the count. These pin the holdoff length to the exact cycle.

Charge events are coincident with low samples, and threshold writes are coincident with samples. These show which of the two wins in each pairing. Soft-reset writes with the command value and with a near-miss value separate a real reset from a decode that ignores the data.

// File: rtl/eod_pkg.sv
package eod_pkg;
  localparam int MV_W    = 12;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int NUM_LVL = 2;   // 0: low warning, 1: empty

  localparam logic [ADDR_W-1:0] ADDR_THR_LOW   = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_THR_EMPTY = 8'h32;
  localparam logic [ADDR_W-1:0] ADDR_LAST_MV   = 8'h34;
  localparam logic [ADDR_W-1:0] ADDR_CMD       = 8'h39;
  localparam logic [DATA_W-1:0] CMD_SOFT_RST   = 16'h0080;

  localparam logic [MV_W-1:0] DEF_THR_LOW   = 12'd1520;
  localparam logic [MV_W-1:0] DEF_THR_EMPTY = 12'd1470;

  typedef logic [NUM_LVL-1:0][MV_W-1:0] thr_vec_t;
endpackage

// File: rtl/eod_regs.sv
module eod_regs
  import eod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [MV_W-1:0]   last_mv_i,
  output thr_vec_t          thr_o,
  output logic              soft_rst_o,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int PAD_W = DATA_W - MV_W;

  thr_vec_t thr_q;
  logic     we_low, we_empty;

  assign soft_rst_o = reg_we_i && (reg_addr_i == ADDR_CMD) && (reg_wdata_i == CMD_SOFT_RST);
  assign we_low     = reg_we_i && (reg_addr_i == ADDR_THR_LOW);
  assign we_empty   = reg_we_i && (reg_addr_i == ADDR_THR_EMPTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q[0] <= DEF_THR_LOW;
      thr_q[1] <= DEF_THR_EMPTY;
    end else if (soft_rst_o) begin
      thr_q[0] <= DEF_THR_LOW;
      thr_q[1] <= DEF_THR_EMPTY;
    end else begin
      if (we_low)   thr_q[0] <= reg_wdata_i[MV_W-1:0];
      if (we_empty) thr_q[1] <= reg_wdata_i[MV_W-1:0];
    end
  end

  assign thr_o = thr_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_THR_LOW:   reg_rdata_o = {{PAD_W{1'b0}}, thr_q[0]};
      ADDR_THR_EMPTY: reg_rdata_o = {{PAD_W{1'b0}}, thr_q[1]};
      ADDR_LAST_MV:   reg_rdata_o = {{PAD_W{1'b0}}, last_mv_i};
      default:        reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/eod_holdoff.sv
module eod_holdoff #(
  parameter int HOLD_CYC = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_rate_i,
  output logic mon_en_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  // Reload on every high-rate cycle, so a re-entry restarts the holdoff
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (hi_rate_i)     cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign mon_en_o = !hi_rate_i && (cnt_q == '0);
endmodule

// File: rtl/eod_flag_bank.sv
module eod_flag_bank
  import eod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [MV_W-1:0]   smp_mv_i,
  input  logic              mon_en_i,
  input  logic              clr_i,
  input  thr_vec_t          thr_i,
  output logic [NUM_LVL-1:0] flag_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic hit, flag_q;
    assign hit = smp_vld_i && mon_en_i && (smp_mv_i < thr_i[g]);

    // Clear wins over a coincident hit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (clr_i) flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/eod_monitor.sv
module eod_monitor
  import eod_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [MV_W-1:0]   smp_mv_i,
  input  logic              hi_rate_i,
  input  logic              chg_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              low_flag_o,
  output logic              empty_flag_o,
  output logic [MV_W-1:0]   last_mv_o
);
  localparam int HOLD_CYC = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;

  thr_vec_t           thr;
  logic               soft_rst, mon_en;
  logic [NUM_LVL-1:0] flags;
  logic [MV_W-1:0]    last_mv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_mv_q <= '0;
    else if (smp_vld_i) last_mv_q <= smp_mv_i;
  end

  eod_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .last_mv_i   (last_mv_q),
    .thr_o       (thr),
    .soft_rst_o  (soft_rst),
    .reg_rdata_o (reg_rdata_o)
  );

  eod_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_rate_i (hi_rate_i),
    .mon_en_o  (mon_en)
  );

  eod_flag_bank u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .smp_mv_i  (smp_mv_i),
    .mon_en_i  (mon_en),
    .clr_i     (chg_evt_i | soft_rst),
    .thr_i     (thr),
    .flag_o    (flags)
  );

  assign low_flag_o   = flags[0];
  assign empty_flag_o = flags[1];
  assign last_mv_o    = last_mv_q;
endmodule

// File: rtl/eod_monitor_chk.sv
module eod_monitor_chk
  import eod_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_vld_i,
  input logic [MV_W-1:0]   smp_mv_i,
  input logic              hi_rate_i,
  input logic              chg_evt_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              low_flag_o,
  input logic              empty_flag_o,
  input logic [MV_W-1:0]   last_mv_o,
  input logic              mon_en,
  input thr_vec_t          thr
);
  logic cmd_rst;
  assign cmd_rst = reg_we_i && reg_addr_i == ADDR_CMD && reg_wdata_i == CMD_SOFT_RST;

  AST_LOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && mon_en && smp_mv_i < thr[0] && !chg_evt_i && !cmd_rst |=> low_flag_o); // R2
  AST_EMPTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && mon_en && smp_mv_i < thr[1] && !chg_evt_i && !cmd_rst |=> empty_flag_o); // R3
  AST_LOW_EQ_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_flag_o && (!smp_vld_i || smp_mv_i >= thr[0]) |=> !low_flag_o); // R2
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_flag_o || empty_flag_o) && !chg_evt_i && !cmd_rst
      |=> (low_flag_o || !$past(low_flag_o)) && (empty_flag_o || !$past(empty_flag_o))); // R4
  AST_CHG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_evt_i |=> !low_flag_o && !empty_flag_o); // R5
  AST_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rate_i && !empty_flag_o |=> !empty_flag_o); // R6
  AST_HOLD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rate_i |=> !mon_en); // R7
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst |=> !low_flag_o && !empty_flag_o && thr[0] == DEF_THR_LOW && thr[1] == DEF_THR_EMPTY); // R9
  AST_LAST_MV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> last_mv_o == $past(smp_mv_i)); // R10
endmodule

bind eod_monitor eod_monitor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_vld_i    (smp_vld_i),
  .smp_mv_i     (smp_mv_i),
  .hi_rate_i    (hi_rate_i),
  .chg_evt_i    (chg_evt_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .low_flag_o   (low_flag_o),
  .empty_flag_o (empty_flag_o),
  .last_mv_o    (last_mv_o),
  .mon_en       (mon_en),
  .thr          (thr)
);

// File: tb/eod_monitor_bench.sv
module eod_monitor_bench;
  localparam int CLK_HZ = 2000;
  localparam int HOLD   = CLK_HZ / 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_vld_i = 1'b0;
  logic [11:0] smp_mv_i = '0;
  logic        hi_rate_i = 1'b0;
  logic        chg_evt_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        low_flag_o, empty_flag_o;
  logic [11:0] last_mv_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  eod_monitor #(.CLK_HZ(CLK_HZ)) u_eod_monitor (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flags_are(input bit lo, input bit em, input string req);
    check(low_flag_o == lo, req, low_flag_o, lo);
    check(empty_flag_o == em, req, empty_flag_o, em);
  endtask

  // Drive one sample for one cycle; outputs are read at the following negedge
  task automatic sample(input int mv);
    smp_vld_i = 1'b1; smp_mv_i = 12'(mv);
    @(negedge clk_i);
    smp_vld_i = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    reg_we_i = 1'b1; reg_addr_i = 8'(a); reg_wdata_i = 16'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_check(input int a, input int exp, input string req);
    reg_addr_i = 8'(a);
    #1;
    check(reg_rdata_o == 16'(exp), req, reg_rdata_o, exp);
  endtask

  task automatic charge();
    chg_evt_i = 1'b1;
    @(negedge clk_i);
    chg_evt_i = 1'b0;
  endtask

  task automatic t_reset();
    flags_are(0, 0, "R1");
    check(last_mv_o == 0, "R1", last_mv_o, 0);
    rd_check(8'h30, 1520, "R1");
    rd_check(8'h32, 1470, "R1");
  endtask

  task automatic t_low_edge();
    sample(1521); flags_are(0, 0, "R2");
    sample(1520); flags_are(0, 0, "R2");
    sample(1519); flags_are(1, 0, "R2");
  endtask

  task automatic t_empty_edge();
    sample(1470); flags_are(1, 0, "R3");
    sample(1469); flags_are(1, 1, "R3");
  endtask

  task automatic t_sticky();
    sample(1600); flags_are(1, 1, "R4");
    sample(4000); flags_are(1, 1, "R4");
    charge();     flags_are(0, 0, "R5");
  endtask

  task automatic t_charge_priority();
    chg_evt_i = 1'b1;
    sample(1000);
    chg_evt_i = 1'b0;
    flags_are(0, 0, "R5");
    check(last_mv_o == 1000, "R10", last_mv_o, 1000);
  endtask

  task automatic t_blank_and_holdoff();
    hi_rate_i = 1'b1;
    @(negedge clk_i);
    sample(1000); flags_are(0, 0, "R6");
    check(last_mv_o == 1000, "R10", last_mv_o, 1000);
    sample(900);
    rd_check(8'h34, 900, "R10");
    hi_rate_i = 1'b0;
    repeat (HOLD - 1) @(negedge clk_i);
    smp_vld_i = 1'b1; smp_mv_i = 12'd1000;
    @(negedge clk_i);
    flags_are(0, 0, "R7");
    @(negedge clk_i);
    smp_vld_i = 1'b0;
    flags_are(1, 1, "R7");
    charge();
  endtask

  task automatic t_holdoff_restart();
    hi_rate_i = 1'b1;
    @(negedge clk_i);
    hi_rate_i = 1'b0;
    repeat (HOLD / 2) @(negedge clk_i);
    hi_rate_i = 1'b1;
    @(negedge clk_i);
    hi_rate_i = 1'b0;
    repeat (HOLD - 1) @(negedge clk_i);
    sample(1000); flags_are(0, 0, "R7");
    sample(1000); flags_are(1, 1, "R7");
    charge();
  endtask

  task automatic t_thr_write();
    wr(8'h30, 1600);
    rd_check(8'h30, 1600, "R8");
    sample(1550); flags_are(1, 0, "R8");
    // Write and sample together: old empty threshold (1470) applies
    reg_we_i = 1'b1; reg_addr_i = 8'h32; reg_wdata_i = 16'd1500;
    smp_vld_i = 1'b1; smp_mv_i = 12'd1480;
    @(negedge clk_i);
    reg_we_i = 1'b0; smp_vld_i = 1'b0;
    flags_are(1, 0, "R8");
    rd_check(8'h32, 1500, "R8");
    sample(1480); flags_are(1, 1, "R8");
  endtask

  task automatic t_soft_reset();
    wr(8'h39, 16'h0081);
    flags_are(1, 1, "R9");
    rd_check(8'h30, 1600, "R9");
    wr(8'h39, 16'h0080);
    flags_are(0, 0, "R9");
    rd_check(8'h30, 1520, "R9");
    rd_check(8'h32, 1470, "R9");
    rd_check(8'h3A, 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_low_edge();
    t_empty_edge();
    t_sticky();
    t_charge_priority();
    t_blank_and_holdoff();
    t_holdoff_restart();
    t_thr_write();
    t_soft_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule